// File: doc/BRIEF.md
# Modulation Ratio Search Engine

This block finds the pair of 8-bit duty counts, a stopped-clock count (ON) and a running-clock count (OFF), whose ratio brings an effective clock frequency closest to a requested target. The effective frequency of a candidate is `stock * OFF / (ON + OFF)`. The block gets a one-cycle `start` together with a target frequency, the undivided stock frequency and a largest allowed total period. It then tries every total period from the largest allowed value down to 1, one candidate per iteration. The results are the best ON and OFF counts, the frequency they give, and a one-cycle `done`.

Each iteration makes two truncating divisions. Both run on a single restoring divider that takes a fixed number of cycles. This keeps the hardware to one multiplier and one divider, and it makes the run time depend only on the total period searched. A controller can start a search, wait for `done`, and copy the counts into its modulation timers. Frequencies can use any unsigned unit, provided the target and the stock frequency use the same one.

Top module: `ratio_search`

## Requirements
- R1: After reset, `on_o`, `off_o` and `freq_o` are 0, and `done_o` and `busy_o` are low.
- R2: A search whose effective largest total period is 0 does no iterations. Its result is ON = 0, OFF = 1 and frequency = stock, and `done_o` rises on the clock edge that accepts `start`.
- R3: A largest total period above 255 on `maxdur_i` is treated as exactly 255. It gives the same results and the same run time as 255.
- R4: For each total period i, from the effective maximum down to 1, the candidate OFF is `floor(target*i/stock)` and the candidate frequency is `floor(stock*OFF/i)`. The search starts from the R2 result with error |stock − target|. A candidate replaces the best when its error |freq − target| is less than or equal to the best error, so on a tie the smaller total period wins. The stock frequency must not be 0.
- R5: The candidate OFF keeps only the low 8 bits of the quotient. ON is (i − OFF) modulo 256. This matters when the target is above the stock frequency.
- R6: `done_o` is high for exactly one cycle. With an effective maximum of m, it rises m·2·(FW+9) clock edges after the edge that accepts `start`.
- R7: `start` has no effect while `busy_o` is high. The running search finishes with the operands it latched and keeps its original run time.
- R8: While the engine is idle, `on_o`, `off_o` and `freq_o` do not change until the next accepted `start`, whatever the operand inputs do.
- R9: `busy_o` is high from the edge that accepts a `start` with m > 0 until the edge that raises `done_o`, and `done_o` is never high together with `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search; accepted only while idle |
| target_i | input | FW | Requested frequency |
| stock_i | input | FW | Undivided frequency, nonzero |
| maxdur_i | input | DW | Largest total period to try (clamped to 255) |
| on_o | output | 8 | Chosen stopped-clock count |
| off_o | output | 8 | Chosen running-clock count |
| freq_o | output | FW+8 | Effective frequency of the chosen pair |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| busy_o | output | 1 | Search in progress |

## Verification
A wrong internal state shows at the ports only when `done_o` fires. A divider that drops or adds a bit, or a misaligned iteration index, leads to a wrong count pair or wrong frequency, or to a `done_o` that comes early or late against the exact cycle count. The bench therefore compares every result with an independent model of the search, and it also counts the edges up to `done_o`. Tie handling is visible only where two periods give the same error, so some vectors are chosen to produce exact ties. A target above the stock frequency exercises the 8-bit wrap.

// File: rtl/ratio_search.sv
module ratio_search #(
  parameter int FW = 18,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] target_i,
  input  logic [FW-1:0] stock_i,
  input  logic [DW-1:0] maxdur_i,
  output logic [7:0]    on_o,
  output logic [7:0]    off_o,
  output logic [FW+7:0] freq_o,
  output logic          done_o,
  output logic          busy_o
);
  localparam int QW = FW + 8;
  localparam int CW = $clog2(QW + 1);

  typedef enum logic [1:0] {S_IDLE, S_OFF, S_FRQ} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [QW-1:0] quo, rem, dvs, best_err;
  logic [FW-1:0] tgt, stk;
  logic [7:0]    idx, c_off;

  logic [FW-1:0] ma;
  logic [7:0]    mb;
  logic [QW-1:0] prod;

  wire [7:0]    md8   = (maxdur_i > DW'(255)) ? 8'hFF : maxdur_i[7:0];
  wire [QW:0]   trial = {rem, quo[QW-1]};
  wire          fits  = trial >= {1'b0, dvs};
  wire [QW:0]   diff  = trial - {1'b0, dvs};
  wire [QW-1:0] tgt_q = QW'(tgt);
  wire [QW-1:0] err   = (quo >= tgt_q) ? quo - tgt_q : tgt_q - quo;
  wire [FW-1:0] err0  = (stock_i >= target_i) ? stock_i - target_i : target_i - stock_i;

  assign busy_o = (st != S_IDLE);

  always_comb begin
    case (st)
      S_OFF:   begin ma = stk;      mb = quo[7:0]; end
      S_FRQ:   begin ma = tgt;      mb = idx - 8'd1; end
      default: begin ma = target_i; mb = md8; end
    endcase
    prod = QW'(ma) * QW'(mb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      quo      <= '0;
      rem      <= '0;
      dvs      <= '0;
      best_err <= '0;
      tgt      <= '0;
      stk      <= '0;
      idx      <= '0;
      c_off    <= '0;
      on_o     <= '0;
      off_o    <= '0;
      freq_o   <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (st != S_IDLE && cnt != '0) begin
        rem <= fits ? diff[QW-1:0] : trial[QW-1:0];
        quo <= {quo[QW-2:0], fits};
        cnt <= cnt - CW'(1);
      end else begin
        case (st)
          S_IDLE: if (start) begin
            tgt      <= target_i;
            stk      <= stock_i;
            on_o     <= 8'd0;
            off_o    <= 8'd1;
            freq_o   <= QW'(stock_i);
            best_err <= QW'(err0);
            if (md8 == 8'd0) begin
              done_o <= 1'b1;
            end else begin
              idx <= md8;
              quo <= prod;
              rem <= '0;
              dvs <= QW'(stock_i);
              cnt <= CW'(QW);
              st  <= S_OFF;
            end
          end
          S_OFF: begin
            c_off <= quo[7:0];
            quo   <= prod;
            rem   <= '0;
            dvs   <= QW'(idx);
            cnt   <= CW'(QW);
            st    <= S_FRQ;
          end
          default: begin
            if (err <= best_err) begin
              on_o     <= idx - c_off;
              off_o    <= c_off;
              freq_o   <= quo;
              best_err <= err;
            end
            if (idx == 8'd1) begin
              done_o <= 1'b1;
              st     <= S_IDLE;
            end else begin
              idx <= idx - 8'd1;
              quo <= prod;
              rem <= '0;
              dvs <= QW'(stk);
              cnt <= CW'(QW);
              st  <= S_OFF;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ratio_search_chk.sv
module ratio_search_chk #(
  parameter int FW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [7:0]    on_o,
  input logic [7:0]    off_o,
  input logic [FW+7:0] freq_o,
  input logic          done_o,
  input logic          busy_o
);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start |=> !busy_o);

  p_start_accepted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start |=> busy_o || done_o);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start |=> $stable(on_o) && $stable(off_o) && $stable(freq_o));

  p_busy_ends_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> busy_o || done_o);
endmodule

bind ratio_search ratio_search_chk #(.FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .on_o(on_o), .off_o(off_o),
  .freq_o(freq_o), .done_o(done_o), .busy_o(busy_o)
);

// File: tb/ratio_search_tb_top.sv
module ratio_search_tb_top;
  localparam int FW = 18;
  localparam int DW = 10;
  localparam int QW = FW + 8;
  localparam int PER = 2 * (QW + 1);
  localparam int NV = 8;

  localparam int unsigned VT[NV] = '{500,    1000, 150000, 33333, 7,    99999,  1000, 0};
  localparam int unsigned VS[NV] = '{1000,   1000, 200000, 66000, 100,  100000, 100,  5000};
  localparam int unsigned VM[NV] = '{4,      3,    60,     90,    20,   40,     30,   12};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [FW-1:0] target_i = '0, stock_i = '0;
  logic [DW-1:0] maxdur_i = '0;
  logic [7:0] on_o, off_o;
  logic [FW+7:0] freq_o;
  logic done_o, busy_o;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ratio_search #(.FW(FW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .target_i(target_i), .stock_i(stock_i),
    .maxdur_i(maxdur_i), .on_o(on_o), .off_o(off_o), .freq_o(freq_o),
    .done_o(done_o), .busy_o(busy_o)
  );

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint adiff(longint a, longint b);
    return (a >= b) ? a - b : b - a;
  endfunction

  function automatic void model(input longint t, input longint s, input longint md,
                                output longint on, output longint off, output longint fr);
    longint be, m;
    m = (md > 255) ? 255 : md;
    on = 0; off = 1; fr = s; be = adiff(s, t);
    for (longint i = m; i > 0; i--) begin
      longint co, cf;
      co = ((t * i) / s) & 255;
      cf = (s * co) / i;
      if (adiff(cf, t) <= be) begin
        be = adiff(cf, t); on = (i - co) & 255; off = co; fr = cf;
      end
    end
  endfunction

  task automatic run(input longint t, input longint s, input longint md, output int lat);
    @(negedge clk);
    target_i = FW'(t); stock_i = FW'(s); maxdur_i = DW'(md); start = 1'b1;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    start = 1'b0;
    while (!done_o && lat < 20000) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    @(negedge clk);
    chk("R6 done one cycle", done_o, 0);
  endtask

  task automatic run_check(string req, longint t, longint s, longint md);
    int lat;
    longint eo, ef, efr, m;
    m = (md > 255) ? 255 : md;
    model(t, s, md, eo, ef, efr);
    run(t, s, md, lat);
    chk({req, " on"}, on_o, eo);
    chk({req, " off"}, off_o, ef);
    chk({req, " freq"}, freq_o, efr);
    chk("R6 latency", lat, m * PER);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk("R1 on", on_o, 0); chk("R1 off", off_o, 0); chk("R1 freq", freq_o, 0);
    chk("R1 done", done_o, 0); chk("R1 busy", busy_o, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) run_check("R4 table", VT[v], VS[v], VM[v]);

    run(500, 1000, 4, lat);
    chk("R4 tie smaller period on", on_o, 1);
    chk("R4 tie smaller period off", off_o, 1);
    chk("R4 tie freq", freq_o, 500);

    run(1000, 1000, 3, lat);
    chk("R4 full speed on", on_o, 0);
    chk("R4 full speed off", off_o, 1);

    run(1234, 4321, 0, lat);
    chk("R2 latency", lat, 0);
    chk("R2 on", on_o, 0); chk("R2 off", off_o, 1); chk("R2 freq", freq_o, 4321);

    run_check("R5 target above stock", 1000, 100, 30);
    run_check("R5 wrap", 90000, 1000, 10);

    run_check("R3 clamp", 12345, 200000, 700);

    @(negedge clk);
    target_i = 500; stock_i = 1000; maxdur_i = 4; start = 1'b1;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    start = 1'b0;
    repeat (10) begin @(posedge clk); lat++; @(negedge clk); end
    chk("R9 busy mid run", busy_o, 1);
    target_i = 3; stock_i = 77; maxdur_i = 9; start = 1'b1;
    @(posedge clk); lat++; @(negedge clk);
    start = 1'b0;
    while (!done_o && lat < 20000) begin @(posedge clk); lat++; @(negedge clk); end
    chk("R7 start ignored latency", lat, 4 * PER);
    chk("R7 start ignored on", on_o, 1);
    chk("R7 start ignored off", off_o, 1);
    chk("R7 start ignored freq", freq_o, 500);

    target_i = 9; stock_i = 11; maxdur_i = 200;
    repeat (20) @(negedge clk);
    chk("R8 hold on", on_o, 1);
    chk("R8 hold off", off_o, 1);
    chk("R8 hold freq", freq_o, 500);
    chk("R9 idle", busy_o, 0);

    for (int r = 0; r < 12; r++) begin
      longint s, t, m;
      s = 1 + ($urandom % ((1 << FW) - 1));
      t = $urandom % (s + 1);
      m = $urandom % 41;
      run_check("R4 random", t, s, m);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule